// File: doc/BRIEF.md
# PCI Cache-Aware Command Selector

This block sits beside a bus-master DMA engine. Before each burst, the engine hands it the direction, the starting byte address, the length in DWORDs, the programmed cache line size and the write-and-invalidate enable. The block returns the 4-bit PCI memory command to issue and the number of DWORDs that this command may move. If the grant is shorter than the request, the engine issues the rest as a later burst.

The choice depends on where the burst lies relative to cache line boundaries. Reads use a line-oriented command whenever the line size is usable and the burst is longer than one DWORD. Writes use write-and-invalidate only for whole lines that start on a line boundary. An unaligned write is trimmed so that it ends on the next boundary, which lets the following burst qualify. The request is taken through a registered handshake: a new request is accepted only after the previous result has been consumed.

Top module: `pci_cmd_select`

## Requirements
- R1: After reset, `cmd_valid` is low and `req_ready` is high.
- R2: A request is captured on a clock edge where `req_valid` and `req_ready` are both high. The result is valid from the next cycle. While `cmd_valid` is high, `req_ready` is low and `cmd_code` and `cmd_len_dw` are held steady until the cycle in which `cmd_accept` is high.
- R3: A line size of zero, or one that is not a power of two, selects plain memory read (reads) or plain memory write (writes), and the full requested length is granted.
- R4: The command codes are: memory read 0110, memory write 0111, memory read multiple 1100, memory read line 1110, memory write and invalidate 1111. Bit 0 of the code is 1 exactly for write commands.
- R5: A read of one DWORD (or zero DWORDs) uses memory read.
- R6: With a usable line size, a read longer than one DWORD that ends inside the line it starts in uses memory read line. The full length is granted.
- R7: With a usable line size, a read that runs past the end of its starting line uses memory read multiple. The full length is granted.
- R8: Memory write and invalidate is chosen only when all three conditions hold: the enable is set, the start address is on a line boundary, and the length is at least one line. The grant is the length rounded down to a whole number of lines.
- R9: With the enable set and a usable line size, a write that is unaligned or shorter than a line uses memory write. Its grant is capped at the number of DWORDs left before the next line boundary.
- R10: With the enable clear, every write uses memory write with the full requested length.
- R11: The cache line size is counted in DWORDs. The offset within a line is (byte address / 4) modulo the line size, so address bits 1:0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Burst descriptor present |
| req_ready | output | 1 | Selector can take a descriptor |
| req_is_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W (32) | Starting byte address |
| req_len_dw | input | LEN_W (12) | Requested length in DWORDs |
| cls_dw | input | CLS_W (8) | Cache line size in DWORDs |
| wr_inv_en | input | 1 | Permit memory write and invalidate |
| cmd_valid | output | 1 | Result held for the engine |
| cmd_accept | input | 1 | Engine consumes the result |
| cmd_code | output | 4 | Selected PCI command code |
| cmd_len_dw | output | LEN_W (12) | DWORDs covered by the command |

## Verification
Reads are tried at lengths of one DWORD, one line and one line plus one, and from mid-line offsets. This separates the plain read, read line and read multiple choices at each boundary. Writes vary the alignment, whether the length is shorter or longer than a line, and the enable bit, so that write-and-invalidate, trimming to the boundary and untrimmed plain writes are each reached. Line sizes of 0, 12, 1, 8 and 128 separate the rules for unusable sizes and for the extreme usable sizes. A pseudo-random sweep then mixes all of these, and the consumer holds each result for a varying number of cycles to exercise the stall path.

// File: rtl/pci_cmd_pkg.sv
// Shared command encodings for the PCI command selector.
package pci_cmd_pkg;
    typedef enum logic [3:0] {
        CMD_MEM_RD      = 4'b0110,
        CMD_MEM_WR      = 4'b0111,
        CMD_MEM_RD_MULT = 4'b1100,
        CMD_MEM_RD_LINE = 4'b1110,
        CMD_MEM_WR_INV  = 4'b1111
    } pci_cmd_e;
endpackage

// File: rtl/line_geom.sv
// Line geometry: decides whether the line size is usable (non-zero and a power
// of two) and finds where the start address falls inside its line.
// Assumes ADDR_W >= CLS_W + 2; the line size is given in DWORDs.
module line_geom #(
    parameter int ADDR_W = 32,
    parameter int CLS_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CLS_W-1:0]  cls,
    output logic              line_ok,
    output logic [CLS_W-1:0]  off_dw,
    output logic [CLS_W:0]    room_dw
);
    logic [CLS_W-1:0] line_mask;

    // Purpose: mask of the DWORD index bits that lie within one line.
    assign line_mask = cls - CLS_W'(1);

    // Purpose: the size is usable only if it is non-zero with a single bit set.
    assign line_ok = (cls != '0) && ((cls & line_mask) == '0);

    // Purpose: DWORD offset inside the line (byte address bits 1:0 are dropped).
    assign off_dw = addr[CLS_W+1:2] & line_mask;

    // Purpose: DWORDs left from the start address to the next line boundary.
    assign room_dw = {1'b0, cls} - {1'b0, off_dw};
endmodule

// File: rtl/cmd_decide.sv
// Command decision: chooses the PCI memory command and the granted length from
// the direction, the length and the line geometry. Purely combinational.
// Assumes LEN_W > CLS_W + 1.
module cmd_decide
    import pci_cmd_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CLS_W = 8
) (
    input  logic              is_write,
    input  logic [LEN_W-1:0]  len_dw,
    input  logic [CLS_W-1:0]  cls,
    input  logic              wr_inv_en,
    input  logic              line_ok,
    input  logic [CLS_W-1:0]  off_dw,
    input  logic [CLS_W:0]    room_dw,
    output pci_cmd_e          cmd,
    output logic [LEN_W-1:0]  grant_dw
);
    localparam int PAD_ROOM = LEN_W - CLS_W - 1;
    localparam int PAD_CLS  = LEN_W - CLS_W;

    logic [LEN_W-1:0] room_ext;
    logic [LEN_W-1:0] cls_ext;
    logic [LEN_W-1:0] whole_lines;
    logic             crosses;
    logic             aligned;

    // Purpose: widen the geometry values to the length width.
    assign room_ext = {{PAD_ROOM{1'b0}}, room_dw};
    assign cls_ext  = {{PAD_CLS{1'b0}}, cls};

    // Purpose: the burst runs past the end of its starting line.
    assign crosses = len_dw > room_ext;
    assign aligned = (off_dw == '0);

    // Purpose: the length rounded down to a whole number of lines.
    assign whole_lines = len_dw & ~(cls_ext - LEN_W'(1));

    // Purpose: pick the command and the length it may cover.
    always_comb begin
        cmd      = CMD_MEM_RD;
        grant_dw = len_dw;
        if (!is_write) begin
            if (!line_ok || (len_dw <= LEN_W'(1))) begin
                cmd = CMD_MEM_RD;
            end else if (crosses) begin
                cmd = CMD_MEM_RD_MULT;
            end else begin
                cmd = CMD_MEM_RD_LINE;
            end
        end else begin
            cmd = CMD_MEM_WR;
            if (line_ok && wr_inv_en) begin
                if (aligned && (len_dw >= cls_ext)) begin
                    cmd      = CMD_MEM_WR_INV;
                    grant_dw = whole_lines;
                end else if (crosses) begin
                    grant_dw = room_ext;
                end
            end
        end
    end
endmodule

// File: rtl/pci_cmd_select.sv
// PCI cache-aware command selector top. It takes one burst descriptor through
// a registered handshake and holds the chosen command and granted length until
// the DMA engine accepts them. The descriptor inputs only need to be valid in
// the cycle where req_valid and req_ready are both high.
module pci_cmd_select
    import pci_cmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  logic [CLS_W-1:0]  cls_dw,
    input  logic              wr_inv_en,
    output logic              cmd_valid,
    input  logic              cmd_accept,
    output logic [3:0]        cmd_code,
    output logic [LEN_W-1:0]  cmd_len_dw
);
    logic             line_ok;
    logic [CLS_W-1:0] off_dw;
    logic [CLS_W:0]   room_dw;
    pci_cmd_e         next_cmd;
    logic [LEN_W-1:0] next_len;

    logic             valid_q;
    pci_cmd_e         cmd_q;
    logic [LEN_W-1:0] len_q;
    logic             take;

    line_geom #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) geom_i (
        .addr    (req_addr),
        .cls     (cls_dw),
        .line_ok (line_ok),
        .off_dw  (off_dw),
        .room_dw (room_dw)
    );

    cmd_decide #(.LEN_W(LEN_W), .CLS_W(CLS_W)) decide_i (
        .is_write  (req_is_write),
        .len_dw    (req_len_dw),
        .cls       (cls_dw),
        .wr_inv_en (wr_inv_en),
        .line_ok   (line_ok),
        .off_dw    (off_dw),
        .room_dw   (room_dw),
        .cmd       (next_cmd),
        .grant_dw  (next_len)
    );

    // Purpose: a new descriptor is taken only once no result is pending.
    assign req_ready = !valid_q;
    assign take      = req_valid && req_ready;

    // Purpose: register the result and hold it until the engine accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cmd_q   <= CMD_MEM_RD;
            len_q   <= '0;
        end else if (take) begin
            valid_q <= 1'b1;
            cmd_q   <= next_cmd;
            len_q   <= next_len;
        end else if (cmd_accept) begin
            valid_q <= 1'b0;
        end
    end

    assign cmd_valid  = valid_q;
    assign cmd_code   = cmd_q;
    assign cmd_len_dw = len_q;

    // A pending result stays unchanged until it is accepted (R2).
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !cmd_accept |=> valid_q && $stable(cmd_q) && $stable(len_q));

    // A captured descriptor produces a result in the next cycle (R2).
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> valid_q);

    // Bit 0 of the command matches the captured direction (R4).
    assert_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cmd_q[0] == $past(req_is_write));

    // The grant never exceeds the request (R9).
    assert_grant_le_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> len_q <= $past(req_len_dw));

    // Write-and-invalidate requires the enable bit (R8, R10).
    assert_mwi_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wr_inv_en |=> cmd_q != CMD_MEM_WR_INV);

    // An unusable line size yields plain commands only (R3).
    assert_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take && !line_ok |=> (cmd_q == CMD_MEM_RD) || (cmd_q == CMD_MEM_WR));
endmodule

// File: tb/pci_cmd_select_tb.sv
module pci_cmd_select_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int CLS_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_is_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len_dw = '0;
    logic [CLS_W-1:0]  cls_dw = '0;
    logic              wr_inv_en = 1'b0;
    logic              cmd_valid;
    logic              cmd_accept = 1'b0;
    logic [3:0]        cmd_code;
    logic [LEN_W-1:0]  cmd_len_dw;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [3:0] exp_code_q[$];
    int         exp_len_q[$];

    pci_cmd_select #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLS_W(CLS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_write(req_is_write), .req_addr(req_addr), .req_len_dw(req_len_dw),
        .cls_dw(cls_dw), .wr_inv_en(wr_inv_en), .cmd_valid(cmd_valid),
        .cmd_accept(cmd_accept), .cmd_code(cmd_code), .cmd_len_dw(cmd_len_dw)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input bit wr, input int addr, input int len, input int cls,
                         input bit en, output logic [3:0] code, output int glen);
        bit usable = 0;
        int off, room;
        for (int k = 0; k < 8; k++) if (cls == (1 << k)) usable = 1;
        glen = len;
        if (!usable) begin
            code = wr ? 4'b0111 : 4'b0110;          // R3
        end else begin
            off  = (addr / 4) % cls;                // R11
            room = cls - off;
            if (!wr) begin
                if (len <= 1)        code = 4'b0110; // R5
                else if (len > room) code = 4'b1100; // R7
                else                 code = 4'b1110; // R6
            end else if (en && off == 0 && len >= cls) begin
                code = 4'b1111;                      // R8
                glen = (len / cls) * cls;
            end else begin
                code = 4'b0111;                      // R9, R10
                if (en && len > room) glen = room;
            end
        end
    endtask

    // Driver: present one descriptor and push its expected result.
    task automatic send(input bit wr, input int addr, input int len, input int cls, input bit en);
        logic [3:0] c;
        int g;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_is_write = wr;
        req_addr     = ADDR_W'(addr);
        req_len_dw   = LEN_W'(len);
        cls_dw       = CLS_W'(cls);
        wr_inv_en    = en;
        req_valid    = 1'b1;
        model(wr, addr, len, cls, en, c, g);
        exp_code_q.push_back(c);
        exp_len_q.push_back(g);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 ready low while result pending", int'(req_ready), 0);
    endtask

    // Monitor: hold each result a varying time, check stability, then compare.
    initial begin
        int seen = 0;
        logic [3:0] c0;
        logic [LEN_W-1:0] l0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                c0 = cmd_code;
                l0 = cmd_len_dw;
                repeat (seen % 3) begin
                    @(negedge clk);
                    check("R2 code held", int'(cmd_code), int'(c0));
                    check("R2 length held", int'(cmd_len_dw), int'(l0));
                end
                if (exp_code_q.size() == 0) begin
                    check("R2 unexpected result", 1, 0);
                end else begin
                    check("R4-coded command (R5 R6 R7 R8 R9 R10 R3)", int'(c0), int'(exp_code_q.pop_front()));
                    check("granted length (R8 R9 R10 R11)", int'(l0), exp_len_q.pop_front());
                end
                seen++;
                cmd_accept = 1'b1;
                @(negedge clk);
                cmd_accept = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lfsr = 32'h1ACE;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cmd_valid after reset", int'(cmd_valid), 0);
        check("R1 req_ready after reset", int'(req_ready), 1);

        send(0, 32'h0,   1, 8, 0);   // R5 single DWORD
        send(0, 32'h0,   8, 8, 0);   // R6 exactly one line
        send(0, 32'h10,  4, 8, 0);   // R6 to the boundary
        send(0, 32'h10,  5, 8, 0);   // R7 one past
        send(0, 32'h13,  5, 8, 0);   // R11 low bits ignored
        send(1, 32'h0,  20, 8, 1);   // R8 rounds to 16
        send(1, 32'h0C, 20, 8, 1);   // R9 unaligned, cap 5
        send(1, 32'h0,   5, 8, 1);   // R9 short aligned
        send(1, 32'h04, 20, 8, 0);   // R10 enable clear
        send(1, 32'h0,  20, 8, 0);   // R10 aligned, enable clear
        send(0, 32'h0,  10, 0, 1);   // R3 zero size
        send(1, 32'h0,  30, 12, 1);  // R3 non power of two
        send(0, 32'h0,   2, 1, 0);   // R7 one-DWORD line
        send(1, 32'h8,   3, 1, 1);   // R8 one-DWORD line
        send(1, 32'h0, 300, 128, 1); // R8 largest line
        send(0, 32'h0, 129, 128, 0); // R7 largest line
        for (int i = 0; i < 60; i++) begin
            int sizes[6] = '{0, 4, 8, 16, 12, 32};
            lfsr = (lfsr << 1) ^ ((lfsr >>> 31) & 1 ? 32'h04C11DB7 : 0);
            send(lfsr[0], int'(lfsr[9:2]) * 4 + int'(lfsr[11:10]),
                 int'(lfsr[17:12]), sizes[int'(lfsr[20:18]) % 6], lfsr[21]);
        end
        while (exp_code_q.size() != 0 || cmd_valid) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule